// File: doc/BRIEF.md
# Two-Tap Fractional Delay Interpolator

This block gives one receive channel of a delay-and-sum beamformer its sub-sample delay. It takes the channel's sample stream after the coarse (whole-sample) delay and forms a weighted sum of the current sample and the one before it. The weights approximate a shift of less than one sample period. It runs at the sample rate and accepts at most one sample per clock.

The two weights are read from two constant lookup tables. The tables are addressed by the probe index, scan-angle index and focal-zone index that arrive with each sample. Each sample can therefore pick a different weight pair. The weights are signed Q2.14 values. The two signed 16x16 products are added at full precision and then clamped into a 32-bit signed result. This clamping affects only the gain-boosted table entries.

Top module: `frac_delay_interp`

## Requirements
- R1: While `rst` is high at a rising edge, and in the cycle after it, `out_valid` is 0 and `out_sample` is 0. A sample presented while `rst` is high is discarded.
- R2: A sample presented with `in_valid` high in cycle n produces `out_valid` high in cycle n+2. `out_valid` is never high except two cycles after an accepted sample.
- R3: `out_sample` = clamp32(h_cur * x[n] + h_prev * x[n-1]). Here x[n] is the accepted sample, x[n-1] is the sample accepted before it, and all values are signed two's complement.
- R4: Let P, A and F be `in_probe`, `in_angle` and `in_focus`, read as unsigned numbers. Let k = (3A + 5F + 7P) mod 17. The base weights are b_prev = 1024k and b_cur = 16384 - b_prev, in Q2.14. The gain is P+1, negated when P is odd. Each weight is gain times its base, clamped to [-32768, 32767].
- R5: Reset clears the history. The first sample accepted after reset uses x[n-1] = 0.
- R6: A cycle with `in_valid` low does not change the history. Two cycles later it gives `out_valid` low, and `out_sample` keeps its previous value.
- R7: A sum above 2147483647 gives 0x7FFFFFFF, and a sum below -2147483648 gives 0x80000000. An example is P=3, A=7, F=0, where both weights are -32768, with two samples of -32768.
- R8: The index fields are sampled in the same cycle as their sample. Consecutive samples with different indices each use their own weight pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 16 | Coarse-delayed sample, signed |
| in_probe | input | 2 | Probe index |
| in_angle | input | 4 | Scan-angle index |
| in_focus | input | 2 | Focal-zone index |
| out_valid | output | 1 | Output sample qualifier |
| out_sample | output | 32 | Fine-delayed sample, signed, clamped |

## Verification
Every result is due exactly two cycles after its input cycle. The weight lookup and the input capture take one register stage. The multiply, add and clamp take the second, which is the output register. The bench drives inputs on the falling edge and carries each expected result through a two-entry pipeline of its own. It compares the ports on the falling edge two cycles later. A reset cycle replaces both pending entries with a zero expectation, because a synchronous reset also discards whatever is in flight.

// File: rtl/fdi_pkg.sv
package fdi_pkg;

  // Weight rule: k = (3A + 5F + 7P) mod 17, base weights split unity (Q2.(w-2)),
  // gain P+1 with sign flipped on odd probes, clamped to the signed coefficient range.
  function automatic int fdi_coef_val(input int probe, input int angle, input int focus,
                                      input int tap, input int coef_w);
    int k;
    int one;
    int base;
    int gain;
    int v;
    int vmax;
    int vmin;
    k    = (3 * angle + 5 * focus + 7 * probe) % 17;
    one  = 1 << (coef_w - 2);
    base = (tap == 0) ? (one - k * (one / 16)) : (k * (one / 16));
    gain = ((probe % 2) == 1) ? -(probe + 1) : (probe + 1);
    v    = gain * base;
    vmax = (1 << (coef_w - 1)) - 1;
    vmin = -(1 << (coef_w - 1));
    if (v > vmax) v = vmax;
    if (v < vmin) v = vmin;
    return v;
  endfunction

endpackage

// File: rtl/fdi_coef_rom.sv
module fdi_coef_rom #(
  parameter int PROBE_W = 2,
  parameter int ANGLE_W = 4,
  parameter int FOCUS_W = 2,
  parameter int COEF_W  = 16,
  parameter int TAP     = 0
) (
  input  logic                                  clk,
  input  logic [PROBE_W+ANGLE_W+FOCUS_W-1:0]    addr,
  output logic signed [COEF_W-1:0]              q
);
  import fdi_pkg::*;

  localparam int ADDR_W = PROBE_W + ANGLE_W + FOCUS_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic signed [COEF_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam int PI = i >> (ANGLE_W + FOCUS_W);
    localparam int AI = (i >> FOCUS_W) % (1 << ANGLE_W);
    localparam int FI = i % (1 << FOCUS_W);
    assign rom[i] = COEF_W'(fdi_coef_val(PI, AI, FI, TAP, COEF_W));
  end

  // synchronous read so the table maps onto a block memory
  always_ff @(posedge clk) begin
    q <= rom[addr];
  end
endmodule

// File: rtl/fdi_tap_line.sv
module fdi_tap_line #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     s_valid,
  output logic signed [DATA_W-1:0] s_cur,
  output logic signed [DATA_W-1:0] s_prev
);
  logic signed [DATA_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      s_valid <= 1'b0;
      s_cur   <= '0;
      s_prev  <= '0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_cur  <= in_sample;
        s_prev <= hist;
        hist   <= in_sample;
      end
    end
  end
endmodule

// File: rtl/fdi_tap_mac.sv
module fdi_tap_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int OUT_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     s_valid,
  input  logic signed [DATA_W-1:0] x_cur,
  input  logic signed [DATA_W-1:0] x_prev,
  input  logic signed [COEF_W-1:0] h_cur,
  input  logic signed [COEF_W-1:0] h_prev,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;

  logic signed [PROD_W-1:0] p_cur;
  logic signed [PROD_W-1:0] p_prev;
  logic signed [SUM_W-1:0]  sum;
  logic signed [OUT_W-1:0]  y;

  assign p_cur  = PROD_W'(x_cur)  * PROD_W'(h_cur);
  assign p_prev = PROD_W'(x_prev) * PROD_W'(h_prev);
  assign sum    = SUM_W'(p_cur) + SUM_W'(p_prev);

  if (SUM_W > OUT_W) begin : g_sat
    localparam int HB = SUM_W - OUT_W + 1;
    logic [HB-1:0] hi;
    assign hi = sum[SUM_W-1 -: HB];
    always_comb begin
      if ((&hi) || !(|hi)) y = sum[OUT_W-1:0];
      else if (sum[SUM_W-1]) y = {1'b1, {(OUT_W-1){1'b0}}};
      else y = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end else begin : g_ext
    assign y = OUT_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= s_valid;
      if (s_valid) out_sample <= y;
    end
  end
endmodule

// File: rtl/frac_delay_interp.sv
module frac_delay_interp #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int OUT_W   = 32,
  parameter int PROBE_W = 2,
  parameter int ANGLE_W = 4,
  parameter int FOCUS_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic [PROBE_W-1:0]       in_probe,
  input  logic [ANGLE_W-1:0]       in_angle,
  input  logic [FOCUS_W-1:0]       in_focus,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);
  localparam int ADDR_W = PROBE_W + ANGLE_W + FOCUS_W;
  localparam int NTAP   = 2;

  logic [ADDR_W-1:0]        coef_addr;
  logic signed [COEF_W-1:0] h [NTAP];
  logic                     s_valid;
  logic signed [DATA_W-1:0] s_cur;
  logic signed [DATA_W-1:0] s_prev;

  assign coef_addr = {in_probe, in_angle, in_focus};

  // tap 0 weights the current sample, tap 1 the previous one
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    fdi_coef_rom #(
      .PROBE_W(PROBE_W), .ANGLE_W(ANGLE_W), .FOCUS_W(FOCUS_W),
      .COEF_W(COEF_W), .TAP(t)
    ) u_rom (
      .clk (clk),
      .addr(coef_addr),
      .q   (h[t])
    );
  end

  fdi_tap_line #(.DATA_W(DATA_W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sample(in_sample),
    .s_valid  (s_valid),
    .s_cur    (s_cur),
    .s_prev   (s_prev)
  );

  fdi_tap_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s_valid),
    .x_cur     (s_cur),
    .x_prev    (s_prev),
    .h_cur     (h[0]),
    .h_prev    (h[1]),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );
endmodule

// File: rtl/fdi_interp_chk.sv
module fdi_interp_chk #(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sample
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_sample == '0));

  // R2
  valid_due_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2 && $past(in_valid, 2)) |-> out_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since_rst == 2'd2 && $past(in_valid, 2)));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !out_valid) |-> $stable(out_sample));
endmodule

bind frac_delay_interp fdi_interp_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sample(out_sample)
);

// File: tb/tb_frac_delay_interp.sv
module tb_frac_delay_interp;
  localparam int CLK_PERIOD = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic [1:0]  in_probe = '0;
  logic [3:0]  in_angle = '0;
  logic [1:0]  in_focus = '0;
  logic        out_valid;
  logic [31:0] out_sample;

  frac_delay_interp dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .in_probe(in_probe), .in_angle(in_angle), .in_focus(in_focus),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // expectation pipeline: kind 0 idle, 1 sample, 2 reset
  int          e_kind [2];
  logic [31:0] e_val  [2];
  string       e_tag  [2];
  logic [31:0] last_out = '0;
  int          prev_x = 0;
  bit          first_after_rst = 1'b1;

  function automatic int weight(int p, int a, int f, bit prev_tap);
    int k, b, g, w;
    k = (3*a + 5*f + 7*p) % 17;
    b = prev_tap ? 1024*k : 16384 - 1024*k;
    case (p)
      0: g = 1;  1: g = -2;  2: g = 3;  default: g = -4;
    endcase
    w = g * b;
    if (w > 32767) w = 32767;
    if (w < -32768) w = -32768;
    return w;
  endfunction

  task automatic check_out();
    logic [31:0] ev;
    logic        evv;
    evv = (e_kind[1] == 1);
    if (e_kind[1] == 1) ev = e_val[1];
    else if (e_kind[1] == 2) ev = '0;
    else ev = last_out;
    checks++;
    if (out_valid !== evv || out_sample !== ev) begin
      fails++;
      $display("FAIL %s: valid=%0b sample=%08h expected valid=%0b sample=%08h",
               e_tag[1], out_valid, out_sample, evv, ev);
    end
    last_out = ev;
  endtask

  // one cycle: check output due now, then drive new inputs at this falling edge
  task automatic cycle(bit r, bit v, int s, int p, int a, int f);
    longint sum;
    int     h0, h1;
    @(negedge clk);
    check_out();
    e_kind[1] = e_kind[0]; e_val[1] = e_val[0]; e_tag[1] = e_tag[0];
    rst = r; in_valid = v; in_sample = 16'(s);
    in_probe = 2'(p); in_angle = 4'(a); in_focus = 2'(f);
    if (r) begin
      e_kind[0] = 2; e_val[0] = '0; e_tag[0] = "R1";
      e_kind[1] = 2; e_val[1] = '0; e_tag[1] = "R1";
      prev_x = 0; first_after_rst = 1'b1;
    end else if (v) begin
      h0 = weight(p, a, f, 1'b0);
      h1 = weight(p, a, f, 1'b1);
      sum = longint'(s) * h0 + longint'(prev_x) * h1;
      e_tag[0] = first_after_rst ? "R5" : "R3/R4/R8";
      if (sum > 64'sd2147483647) begin sum = 64'sd2147483647; e_tag[0] = "R7"; end
      if (sum < -64'sd2147483648) begin sum = -64'sd2147483648; e_tag[0] = "R7"; end
      e_kind[0] = 1; e_val[0] = 32'(sum);
      prev_x = s; first_after_rst = 1'b0;
    end else begin
      e_kind[0] = 0; e_val[0] = '0; e_tag[0] = "R6/R2";
    end
  endtask

  task automatic rand_cycle(int valid_pct);
    cycle(1'b0, ($urandom % 100) < valid_pct, $signed(16'($urandom)),
          $urandom % 4, $urandom % 16, $urandom % 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin e_kind[i] = 2; e_val[i] = '0; e_tag[i] = "R1"; end
    // R1, R5: samples offered during reset must be dropped
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 12345, 1, 3, 2);
    // R5: first sample after reset sees a zero history; R4 entry (0,0,0)
    cycle(1'b0, 1'b1, 1000, 0, 0, 0);
    cycle(1'b0, 1'b1, -2000, 0, 1, 1);
    // R6: idle gap, history must stay at -2000
    cycle(1'b0, 1'b0, 777, 3, 3, 3);
    cycle(1'b0, 1'b0, 555, 2, 2, 2);
    cycle(1'b0, 1'b1, 300, 2, 5, 3);
    // R7: gain-boosted entry with both weights -32768
    cycle(1'b0, 1'b1, -32768, 3, 7, 0);
    cycle(1'b0, 1'b1, -32768, 3, 7, 0);
    cycle(1'b0, 1'b1, 32767, 3, 7, 0);
    // R8: index changes every sample, back-to-back
    for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, i * 1111 - 9000, i % 4, i, (i * 3) % 4);
    // constrained random mix
    for (int i = 0; i < 1500; i++) rand_cycle(70);
    // R1, R5 again: reset mid-stream with samples in flight
    cycle(1'b1, 1'b1, 4000, 1, 1, 1);
    cycle(1'b0, 1'b1, 4000, 1, 1, 1);
    for (int i = 0; i < 500; i++) rand_cycle(40);
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 0, 0, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule